// File: doc/BRIEF.md
# Two-Level Carry-Skip Adder

This block adds two unsigned operands and a carry-in in one combinational pass and returns the sum together with a carry-out. The operand is cut into equal groups of bits, four groups of four bits at the default width. Inside each group the carry ripples from bit to bit. Each group also forms the AND of its bit propagates. When every bit of a group propagates, the carry leaving the group is taken straight from the carry entering it, so the group's own chain is bypassed.

An optional second level of bypass can be selected by parameter. It pairs adjacent groups, ANDs their group propagates, and lets the carry jump over both groups of a pair at once. Both variants give the same arithmetic result. They differ only in the path a carry takes through the groups.

The block sits in a datapath wherever a fixed-width add with carry-in and carry-out is needed. It has no clock and no state.

Top module: `csk_adder16`

## Requirements
- R1: For all inputs, the 17-bit value {cout, sum} equals the zero-extended operand a plus the zero-extended operand b plus cin.
- R2: A bit position where both operand bits are 1 sends a carry of 1 into the next position. A position where both are 0 sends a carry of 0. In both cases the carry entering that position has no effect on the carry it sends on.
- R3: When every bit of a and b differs (a XOR b all ones), cout equals cin, and every bit of sum equals the inverse of cin.
- R4: When a group does not fully propagate, the carry it sends out is set by its own generate and kill bits and does not depend on its carry-in. For example, a=0x000F and b=0x0001 give sum 0x0010 and cout 0 for cin 0 and cin 1 alike, apart from sum bit 0.
- R5: A carry generated in bit 0 and propagated through all higher bits reaches the top. a=0xFFFF, b=0x0001, cin=0 gives sum 0x0000 and cout 1.
- R6: The carry entering each group boundary (bits 4, 8 and 12 at the default width) equals the carry of the arithmetic sum of the operand bits below that boundary plus cin.
- R7: The variant with the second skip level (SKIP2=1) and the variant without it (SKIP2=0) give identical sum and cout for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
Two functions can act on the same result at once: the ripple inside a group and the bypass mux around it. Both are active when a group fully propagates while the group below it generates. Operands are built so that a carry is born in one group and then meets one or more fully propagating groups, for example 0xFFFF plus 0x0001, or patterns with the all-propagate region starting at a group boundary. Random vectors with propagate-heavy operands then mix the two functions. The result of each is judged against a bench-computed 17-bit sum on both the SKIP2=1 and the SKIP2=0 build.

// File: rtl/csk_pkg.sv
// Package: shared sizing for the carry-skip adder.
// Assumes the data width is a whole multiple of the group width.
package csk_pkg;
    parameter int unsigned CSK_WIDTH = 16;
    parameter int unsigned CSK_GW    = 4;
    localparam int unsigned CSK_NGRP = CSK_WIDTH / CSK_GW;
endpackage

// File: rtl/csk_bitcell.sv
// Module: csk_bitcell
// Forms the generate, propagate and kill terms of one bit position.
// Assumes nothing about neighbouring bits; purely combinational.
module csk_bitcell (
    input  logic x,
    input  logic y,
    output logic gen,
    output logic prop,
    output logic kill
);
    // Classify the bit pair.
    always_comb begin
        gen  = x & y;
        prop = x ^ y;
        kill = ~x & ~y;
    end
endmodule

// File: rtl/csk_group.sv
// Module: csk_group
// One ripple group with a bypass around it. The carry leaves the group
// from the group carry-in when all bits propagate, otherwise from the
// end of the internal ripple chain.
// Assumes GW >= 1.
module csk_group #(
    parameter int unsigned GW = 4
) (
    input  logic [GW-1:0] x,
    input  logic [GW-1:0] y,
    input  logic          cin_g,
    output logic [GW-1:0] s,
    output logic          cout_g,
    output logic          bprop
);
    logic [GW-1:0] gv;
    logic [GW-1:0] pv;
    logic [GW-1:0] kv;
    logic [GW:0]   rc;

    assign rc[0] = cin_g;

    for (genvar i = 0; i < GW; i++) begin : g_bit
        csk_bitcell u_cell (
            .x    (x[i]),
            .y    (y[i]),
            .gen  (gv[i]),
            .prop (pv[i]),
            .kill (kv[i])
        );
        // Ripple step: generate forces 1, kill forces 0, else pass.
        assign rc[i+1] = gv[i] | (~kv[i] & rc[i]);
        // Sum bit from the local propagate and the incoming carry.
        assign s[i]    = pv[i] ^ rc[i];
    end

    // Group propagate and bypass mux.
    always_comb begin
        bprop  = &pv;
        cout_g = bprop ? cin_g : rc[GW];
    end
endmodule

// File: rtl/csk_skip2.sv
// Module: csk_skip2
// Second-level bypass over a pair of adjacent groups. When both groups
// propagate, the carry into the lower group is passed over the pair.
// Assumes the two group propagates come from neighbouring groups.
module csk_skip2 (
    input  logic bp_lo,
    input  logic bp_hi,
    input  logic c_pair_in,
    input  logic c_hi_out,
    output logic c_pair_out
);
    // Select the pair-level carry.
    always_comb begin
        c_pair_out = (bp_lo & bp_hi) ? c_pair_in : c_hi_out;
    end
endmodule

// File: rtl/csk_adder16.sv
// Module: csk_adder16 (top)
// Carry-skip adder built from ripple groups with a first-level bypass
// per group and, when SKIP2=1, a second-level bypass per group pair.
// Assumes WIDTH is a multiple of GW, and with SKIP2=1 an even group count.
module csk_adder16 #(
    parameter int unsigned WIDTH = csk_pkg::CSK_WIDTH,
    parameter int unsigned GW    = csk_pkg::CSK_GW,
    parameter bit          SKIP2 = 1'b1
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int unsigned NGRP = WIDTH / GW;

    logic [NGRP:0]   gcarry;
    logic [NGRP-1:0] gout;
    logic [NGRP-1:0] gbp;

    assign gcarry[0] = cin;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        csk_group #(.GW(GW)) u_grp (
            .x      (a[g*GW +: GW]),
            .y      (b[g*GW +: GW]),
            .cin_g  (gcarry[g]),
            .s      (sum[g*GW +: GW]),
            .cout_g (gout[g]),
            .bprop  (gbp[g])
        );
        if (SKIP2 && (g % 2 == 1)) begin : g_pair
            csk_skip2 u_skip2 (
                .bp_lo      (gbp[g-1]),
                .bp_hi      (gbp[g]),
                .c_pair_in  (gcarry[g-1]),
                .c_hi_out   (gout[g]),
                .c_pair_out (gcarry[g+1])
            );
        end else begin : g_single
            assign gcarry[g+1] = gout[g];
        end
    end

    // Carry out of the top group.
    assign cout = gcarry[NGRP];
endmodule

// File: rtl/csk_adder16_chk.sv
// Module: csk_adder16_chk
// Assertion checker attached to csk_adder16 by bind. It compares ports and
// internal group carries with arithmetic computed here.
module csk_adder16_chk #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned GW    = 4
) (
    input logic [WIDTH-1:0]    a,
    input logic [WIDTH-1:0]    b,
    input logic                cin,
    input logic [WIDTH-1:0]    sum,
    input logic                cout,
    input logic [WIDTH/GW:0]   gcarry
);
    localparam int unsigned NGRP = WIDTH / GW;

    // Port-level properties.
    always_comb begin
        assert_total_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
            else $error("R1 total mismatch");
        if (&(a ^ b)) begin
            assert_bypass_all_R3: assert (cout == cin && sum == {WIDTH{~cin}})
                else $error("R3 full propagate mismatch");
        end
        if (a[WIDTH-1] & b[WIDTH-1]) begin
            assert_gen_top_R2: assert (cout) else $error("R2 generate at top");
        end
        if (~a[WIDTH-1] & ~b[WIDTH-1]) begin
            assert_kill_top_R2: assert (!cout) else $error("R2 kill at top");
        end
    end

    // Internal group-boundary carries versus low-part arithmetic.
    always_comb begin
        logic [WIDTH:0] m;
        logic [WIDTH:0] t;
        for (int g = 1; g <= NGRP; g++) begin
            m = ({{WIDTH{1'b0}}, 1'b1} << (g * GW)) - 1'b1;
            t = ({1'b0, a} & m) + ({1'b0, b} & m) + {{WIDTH{1'b0}}, cin};
            assert_boundary_R6: assert (gcarry[g] == t[g*GW])
                else $error("R6 boundary carry mismatch");
        end
    end
endmodule

bind csk_adder16 csk_adder16_chk #(.WIDTH(WIDTH), .GW(GW)) u_chk (
    .a      (a),
    .b      (b),
    .cin    (cin),
    .sum    (sum),
    .cout   (cout),
    .gcarry (gcarry)
);

// File: tb/sim_csk_adder16.sv
// Bench for csk_adder16: directed corners plus seeded random vectors,
// both skip variants compared against a bench-computed sum.
module sim_csk_adder16;
    logic        clk;
    logic        rst_n;
    logic [15:0] a;
    logic [15:0] b;
    logic        cin;
    logic [15:0] sum0, sum1;
    logic        cout0, cout1;
    int          checks;
    int          errors;
    int          cycles;
    bit          done;

    csk_adder16 #(.SKIP2(1'b1)) u0 (.a(a), .b(b), .cin(cin), .sum(sum0), .cout(cout0));
    csk_adder16 #(.SKIP2(1'b0)) u1 (.a(a), .b(b), .cin(cin), .sum(sum1), .cout(cout1));

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Expected 17-bit result from the arithmetic definition.
    function automatic logic [16:0] ref_add(input logic [15:0] x, input logic [15:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {16'd0, c};
    endfunction

    task automatic cmp(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (a=%h b=%h cin=%b)", req, act, exp, a, b, cin);
        end
    endtask

    // Drive one vector at the falling edge, sample mid-cycle.
    task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c, input string req);
        @(negedge clk);
        a = x; b = y; cin = c;
        #5;
        cmp(req, {cout0, sum0}, ref_add(x, y, c));
        cmp("R7", {cout1, sum1}, {cout0, sum0});
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [16:0] r_lo, r_hi;
        checks = 0; errors = 0; cycles = 0; done = 1'b0;
        rst_n = 1'b0; a = '0; b = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state: zero inputs give zero outputs (R1).
        #5;
        cmp("R1", {cout0, sum0}, 17'd0);

        // R3: every bit propagates, carry-in passes to the top.
        apply(16'hFFFF, 16'h0000, 1'b1, "R3");
        cmp("R3", {cout0, sum0}, {1'b1, 16'h0000});
        apply(16'hFFFF, 16'h0000, 1'b0, "R3");
        cmp("R3", {cout0, sum0}, {1'b0, 16'hFFFF});
        apply(16'hA5C3, 16'h5A3C, 1'b1, "R3");
        cmp("R3", {cout0, sum0}, {1'b1, 16'h0000});

        // R5: generated at bit 0, travels to the top.
        apply(16'hFFFF, 16'h0001, 1'b0, "R5");
        cmp("R5", {cout0, sum0}, {1'b1, 16'h0000});

        // R2: generate and kill at a bit, independent of carry below.
        apply(16'h0010, 16'h0010, 1'b1, "R2");
        cmp("R2", {cout0, sum0}, 17'h00021);
        apply(16'h000F, 16'h0000, 1'b1, "R2");
        cmp("R2", {cout0, sum0}, 17'h00010);
        apply(16'h8000, 16'h8000, 1'b0, "R2");
        cmp("R2", {cout0, sum0}, 17'h10000);

        // R4: group 0 generates itself; carry-in changes only bit 0.
        apply(16'h000F, 16'h0001, 1'b0, "R4");
        r_lo = {cout0, sum0};
        apply(16'h000F, 16'h0001, 1'b1, "R4");
        r_hi = {cout0, sum0};
        cmp("R4", r_lo, 17'h00010);
        cmp("R4", r_hi, 17'h00011);

        // R6: carry born at each boundary then bypassing upper groups.
        apply(16'hFFF8, 16'h0008, 1'b0, "R6");
        apply(16'hFF80, 16'h0080, 1'b0, "R6");
        apply(16'hF800, 16'h0800, 1'b0, "R6");
        apply(16'h0FFF, 16'h0001, 1'b0, "R6");
        apply(16'hF0FF, 16'h0F01, 1'b0, "R6");

        // Random vectors, half of them propagate-heavy (R1, R7).
        void'($urandom(32'd20240613));
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] x, y;
            x = 16'($urandom);
            y = 16'($urandom);
            if (n % 2 == 1) y = ~x ^ (16'h1 << ($urandom % 16));
            apply(x, y, 1'($urandom), "R1");
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule